// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. It brings the bus back to a known state after a transfer was cut short, after power was lost, or after a reset left a target device holding the data line low. When a recovery request arrives, the sequencer clocks the bus repeatedly. During each high half of the clock it looks at the data line. The first time it finds the data line released high, it drives a START condition and then a STOP condition, which leaves the bus idle. If the data line is still low after the last permitted clock, it gives up. It then releases both lines and reports a failure.

The sequencer only ever pulls a line low. A release lets the external pull-up raise the line. The two outputs are therefore pull-enable signals for open-drain pads. The data input must already be synchronised to `clk`. The low and high half-period lengths are counted in `clk` cycles and come from two input ports. This lets one netlist meet either standard bus speed. The high count also sets the START hold and the STOP setup intervals, so it should be chosen to meet whichever of those minimums is larger.

States: `ST_IDLE` (both released), `ST_CLK_LOW` (clock pulled), `ST_CLK_HIGH` (clock released, data sampled on the last cycle), `ST_START_HOLD` (data pulled with clock released), `ST_STOP_LOW` (both pulled), `ST_STOP_SETUP` (clock released, data pulled), `ST_FINISH` (both released, done pulse), `ST_GIVE_UP` (both released, done pulse with failure).

Transitions:
- `ST_IDLE` to `ST_CLK_LOW` on a request.
- `ST_CLK_LOW` to `ST_CLK_HIGH` when the low timer expires.
- From `ST_CLK_HIGH`, when the high timer expires, there are three outcomes:
  - to `ST_START_HOLD` if data is high;
  - to `ST_GIVE_UP` if data is low on the final clock;
  - otherwise back to `ST_CLK_LOW`.
- `ST_START_HOLD` to `ST_STOP_LOW`, `ST_STOP_LOW` to `ST_STOP_SETUP`, and `ST_STOP_SETUP` to `ST_FINISH`, each on timer expiry.
- `ST_FINISH` and `ST_GIVE_UP` return to `ST_IDLE` after one cycle.

Top module: `bus_recover_seq`

## Requirements
- R1: After reset both pull outputs are 0 (lines released), and `done`, `failed` and `busy` are 0.
- R2: A request seen in idle makes `scl_pull` 1 from the next cycle for exactly `lo_cycles` cycles. It is followed by `hi_cycles` cycles with `scl_pull` 0, and `sda_pull` stays 0 throughout these clock phases.
- R3: `sda_in` is sampled on the last cycle of each clock-high phase, and at most NUM_CLOCKS (default 9) clock-high phases are produced per request.
- R4: When the sample finds `sda_in` = 1, `sda_pull` goes to 1 while `scl_pull` stays 0, and it holds for `hi_cycles` cycles (START).
- R5: After the START, `scl_pull` is 1 for `lo_cycles` cycles, then 0 for `hi_cycles` cycles, with `sda_pull` held at 1 throughout. After that `sda_pull` returns to 0 (STOP).
- R6: In the cycle in which the STOP releases the data line, `done` is 1 for that one cycle and `failed` is 0.
- R7: If `sda_in` is 0 at the sample of the final clock-high phase, both pulls go to 0 and `done` and `failed` are both 1. `failed` then stays 1 until the next accepted request clears it.
- R8: `req` has no effect while `busy` is 1; the output sequence is unchanged.
- R9: `sda_pull` only changes while `scl_pull` is 0 and not changing in the same cycle.
- R10: `busy` is 1 from the cycle after an accepted request through the `done` cycle inclusive, and it is 0 otherwise. In idle both pulls are 0.
- R11: A `lo_cycles` or `hi_cycles` value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a recovery (accepted in idle only) |
| lo_cycles | input | CNT_W | Clock-low half-period in `clk` cycles |
| hi_cycles | input | CNT_W | Clock-high half-period, START hold and STOP setup, in `clk` cycles |
| sda_in | input | 1 | Synchronised level of the data line |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle pulse at the end of a recovery |
| failed | output | 1 | Last recovery ended with data still low |

## Verification
The pull outputs are decoded directly from the state register. A wrong state or a wrong transition therefore appears on `scl_pull`, `sda_pull` or `busy` in the very next cycle. A half-period timer that is off by one shifts the next edge of the pulls by a cycle. A wrong count of clock-high phases shows up as an extra or a missing clock before the START, or as a `failed` result one phase too early or too late. The bench replays the expected pull, done, failed and busy levels every cycle. It uses a target model that releases the data line after a chosen number of clocks, so any of these faults is visible within one cycle of its first effect.

// File: rtl/bus_recover_pkg.sv
package bus_recover_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_START_HOLD,
        ST_STOP_LOW,
        ST_STOP_SETUP,
        ST_FINISH,
        ST_GIVE_UP
    } rec_state_t;

endpackage

// File: rtl/brs_phase_timer.sv
module brs_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/brs_clock_counter.sv
module brs_clock_counter #(
    parameter int LIMIT = 9,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic at_limit
);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (bump && (count_q != CW'(LIMIT))) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign at_limit = (count_q == CW'(LIMIT));

endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq
    import bus_recover_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int NUM_CLOCKS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] lo_cycles,
    input  logic [CNT_W-1:0] hi_cycles,
    input  logic             sda_in,
    output logic             scl_pull,
    output logic             sda_pull,
    output logic             busy,
    output logic             done,
    output logic             failed
);

    rec_state_t       state_q, state_d;
    logic             fail_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic             cnt_clear, cnt_bump, cnt_last;
    logic [CNT_W-1:0] lo_reload, hi_reload;

    // A half-period of N cycles loads N-1; zero is treated as one cycle (R11)
    assign lo_reload = (lo_cycles == '0) ? '0 : lo_cycles - 1'b1;
    assign hi_reload = (hi_cycles == '0) ? '0 : hi_cycles - 1'b1;

    brs_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    brs_clock_counter #(.LIMIT(NUM_CLOCKS)) u_clocks (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .bump     (cnt_bump),
        .at_limit (cnt_last)
    );

    // Next-state and sequencing controls
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = lo_reload;
        cnt_clear = 1'b0;
        cnt_bump  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d   = ST_CLK_LOW;
                    tmr_load  = 1'b1;
                    tmr_val   = lo_reload;
                    cnt_clear = 1'b1;
                end
            end
            ST_CLK_LOW: begin
                if (tmr_exp) begin
                    state_d  = ST_CLK_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = hi_reload;
                    cnt_bump = 1'b1;
                end
            end
            ST_CLK_HIGH: begin
                if (tmr_exp) begin
                    if (sda_in) begin
                        state_d  = ST_START_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = hi_reload;
                    end else if (cnt_last) begin
                        state_d = ST_GIVE_UP;
                    end else begin
                        state_d  = ST_CLK_LOW;
                        tmr_load = 1'b1;
                        tmr_val  = lo_reload;
                    end
                end
            end
            ST_START_HOLD: begin
                if (tmr_exp) begin
                    state_d  = ST_STOP_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = lo_reload;
                end
            end
            ST_STOP_LOW: begin
                if (tmr_exp) begin
                    state_d  = ST_STOP_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = hi_reload;
                end
            end
            ST_STOP_SETUP: begin
                if (tmr_exp) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH:  state_d = ST_IDLE;
            ST_GIVE_UP: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and sticky failure flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req) begin
                fail_q <= 1'b0;
            end else if (state_q == ST_CLK_HIGH && state_d == ST_GIVE_UP) begin
                fail_q <= 1'b1;
            end
        end
    end

    // Outputs decoded from the current state
    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:       busy = 1'b0;
            ST_CLK_LOW:    scl_pull = 1'b1;
            ST_CLK_HIGH:   ;
            ST_START_HOLD: sda_pull = 1'b1;
            ST_STOP_LOW: begin
                scl_pull = 1'b1;
                sda_pull = 1'b1;
            end
            ST_STOP_SETUP: sda_pull = 1'b1;
            ST_FINISH:     done = 1'b1;
            ST_GIVE_UP:    done = 1'b1;
            default:       busy = 1'b0;
        endcase
    end

    assign failed = fail_q;

endmodule

// File: rtl/bus_recover_chk.sv
module bus_recover_chk #(
    parameter int NUM_CLOCKS = 9
) (
    input logic clk,
    input logic rst_n,
    input logic scl_pull,
    input logic sda_pull,
    input logic busy,
    input logic done,
    input logic failed
);

    int unsigned rises;

    // Clock-line releases with the data line released, per recovery
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rises <= 0;
        end else if (!busy) begin
            rises <= 0;
        end else if (scl_pull == 1'b0 && $past(scl_pull) && !sda_pull) begin
            rises <= rises + 1;
        end
    end

    p_clock_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rises <= NUM_CLOCKS);

    p_data_moves_clock_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> (!scl_pull && $stable(scl_pull)));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_pull && !sda_pull && !done));

    p_fail_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && failed) |-> (!scl_pull && !sda_pull));

    p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind bus_recover_seq bus_recover_chk #(.NUM_CLOCKS(NUM_CLOCKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .busy     (busy),
    .done     (done),
    .failed   (failed)
);

// File: tb/bus_recover_seq_test.sv
module bus_recover_seq_test;

    localparam int CNT_W = 16;
    localparam int NCLK  = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0;
    logic [CNT_W-1:0] lo_cycles = 16'd2;
    logic [CNT_W-1:0] hi_cycles = 16'd2;
    logic             scl_pull, sda_pull, busy, done, failed;
    logic             target_hold = 1'b0;
    logic             sda_in;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [4:0] expq[$];   // {scl_pull, sda_pull, done, failed, busy}

    assign sda_in = !sda_pull && !target_hold;

    always #4 clk = ~clk;   // 125 MHz

    bus_recover_seq #(.CNT_W(CNT_W), .NUM_CLOCKS(NCLK)) uut (
        .clk(clk), .rst_n(rst_n), .req(req),
        .lo_cycles(lo_cycles), .hi_cycles(hi_cycles), .sda_in(sda_in),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy),
        .done(done), .failed(failed)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got {scl,sda,done,fail,busy}=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push_n(input int n, input logic [4:0] v);
        for (int i = 0; i < n; i++) expq.push_back(v);
    endtask

    // Expected output trace; rel = clock-high phase at which the target lets go
    task automatic build(input int lo, input int hi, input int rel);
        int l = (lo < 1) ? 1 : lo;
        int h = (hi < 1) ? 1 : hi;
        expq.delete();
        for (int k = 1; k <= NCLK; k++) begin
            push_n(l, 5'b10001);              // R2 clock low
            push_n(h, 5'b00001);              // R2 clock high, sample at end (R3)
            if (k >= rel) begin
                push_n(h, 5'b01001);          // R4 START hold
                push_n(l, 5'b11001);          // R5 STOP low
                push_n(h, 5'b01001);          // R5 STOP setup
                push_n(1, 5'b00101);          // R6 done
                push_n(2, 5'b00000);          // R10 idle
                return;
            end
        end
        push_n(1, 5'b00111);                  // R7 give up
        push_n(2, 5'b00010);                  // R7 failure held
    endtask

    task automatic run_case(input string tag, input int lo, input int hi, input int rel, input bit poke);
        int rises = 0;
        bit prev_high = 1'b1;
        lo_cycles = CNT_W'(lo);
        hi_cycles = CNT_W'(hi);
        build(lo, hi, rel);
        target_hold = (rel > 1);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int idx = 0; expq.size() > 0; idx++) begin
            check(tag, {scl_pull, sda_pull, done, failed, busy}, expq.pop_front());
            if (!scl_pull && !prev_high) rises++;
            prev_high = !scl_pull;
            if (rel > 1) target_hold = (rises < rel);
            req = poke && (idx == 3 || idx == 7);  // R8 requests while busy
            @(negedge clk);
        end
        req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {scl_pull, sda_pull, done, failed, busy}, 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {scl_pull, sda_pull, done, failed, busy}, 5'b00000);
        run_case("R2 R4 R5 R6 first clock", 3, 2, 1, 0);
        run_case("R3 release on fourth clock", 2, 1, 4, 0);
        run_case("R3 release on last clock", 4, 3, 9, 0);
        run_case("R7 R3 never released", 2, 2, 10, 0);
        run_case("R11 R7 zero counts clear failure", 0, 0, 2, 0);
        run_case("R8 request while busy", 3, 2, 3, 1);
        run_case("R9 R10 long phases", 5, 4, 6, 0);
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got running expected finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule